// File: doc/BRIEF.md
# Refresh Engine and Bus Owner Arbiter

This block decides which of four agents drives the shared memory bus: the processor, a DMA engine, an internal memory refresh engine, or an external master that asks for the bus through a hold request and acknowledge handshake. A programmable divider produces refresh requests at a fixed spacing in clock cycles. A refresh request always wins arbitration. When it does, the block runs a refresh cycle of a fixed length and drives the current row address. When the cycle ends, the row address moves on by one or two, depending on the data bus width.

A bus owner never loses the bus in the middle of its own transfer. The processor and the DMA engine signal the end of each bus cycle with `cyc_done_i`, and ownership can change only at that point. A refresh owner keeps the bus for its full cycle length. An external owner keeps the bus until it drops its hold request. If a refresh becomes due while an external master holds the bus, the acknowledge is withdrawn to ask for the bus back. Refresh requests that cannot be served at once are queued in a small counter and then served back to back.

Top module: `rfsh_bus_arbiter`

## Requirements
- R1: After reset the owner is the processor (`owner_o` = 2'b00), `hold_ack_o` and `rfsh_active_o` are low, `rfsh_addr_o` is zero, and the first refresh uses row address zero.
- R2: With `div_i` = N and N nonzero, a refresh request arises once every N clock cycles. With `div_i` = 0, no refresh request arises.
- R3: A refresh cycle keeps `rfsh_active_o` high and `owner_o` = 2'b10 for exactly RFSH_LEN cycles. During those cycles `rfsh_addr_o` holds the row address steadily. Outside refresh cycles `rfsh_addr_o` is zero.
- R4: Each refresh cycle advances the row address by 1 when `wide_bus_i` = 0 and by 2 when `wide_bus_i` = 1.
- R5: The row address wraps from its maximum value through zero, modulo 2^ADDR_W.
- R6: At a release point the next owner is chosen in this order: a pending refresh (2'b10), then the hold requester (2'b11), then DMA (2'b01), then the processor (2'b00).
- R7: While the processor or DMA owns the bus, ownership changes only in the cycle after `cyc_done_i` was high. A refresh owner releases only after its last cycle.
- R8: `hold_ack_o` is high only while the external master owns the bus and no refresh is pending. The external master keeps the bus until `hold_req_i` goes low.
- R9: A refresh request that arrives during an external hold drops `hold_ack_o` without taking the bus. The refresh takes the bus in the cycle after `hold_req_i` goes low.
- R10: Up to 7 refresh requests can queue, and extra requests are discarded. All queued requests are served back to back, so `rfsh_active_o` stays high across them, and then the bus goes to the next owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Refresh spacing in cycles; 0 turns refresh off |
| wide_bus_i | input | 1 | 1 selects 16-bit bus mode (row step 2), 0 selects 8-bit mode (step 1) |
| cyc_done_i | input | 1 | Current processor or DMA bus cycle ends this clock |
| dma_req_i | input | 1 | DMA engine wants the bus |
| hold_req_i | input | 1 | External master wants the bus |
| hold_ack_o | output | 1 | Bus granted to the external master |
| owner_o | output | 2 | Current owner: 00 processor, 01 DMA, 10 refresh, 11 external |
| rfsh_active_o | output | 1 | A refresh cycle is on the bus |
| rfsh_addr_o | output | ADDR_W | Row address during refresh, zero otherwise |

## Verification
A wrong divider count or a lost queued request shows up as a wrong spacing between refresh starts, or as a missing start, within one interval. A wrong address counter shows up at the next refresh start as a mismatch on `rfsh_addr_o`. A wrap error shows up after 2^ADDR_W refreshes. A priority or release-point error in the owner state changes `owner_o` one clock after the triggering edge. The bench therefore compares every refresh start and every owner transition against a model driven only by the port stimulus.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        OWN_CPU  = 2'b00,
        OWN_DMA  = 2'b01,
        OWN_RFSH = 2'b10,
        OWN_HOLD = 2'b11
    } owner_e;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int DIV_W  = 8,
    parameter int PEND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             take_i,
    output logic             pending_o
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [PEND_W-1:0] pend;
    } ivl_t;

    ivl_t st_d, st_q;
    logic tick;

    // A request arises when the spacing counter reaches its last step.
    assign tick = (div_i != '0) && (st_q.cnt >= div_i - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (tick || (div_i == '0)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        if (tick && !take_i) begin
            if (st_q.pend != PEND_MAX) begin
                st_d.pend = st_q.pend + PEND_W'(1);
            end
        end else if (!tick && take_i) begin
            st_d.pend = st_q.pend - PEND_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = (st_q.pend != '0);

endmodule

// File: rtl/rfsh_cycle.sv
module rfsh_cycle #(
    parameter int ADDR_W   = 16,
    parameter int RFSH_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              active_i,
    input  logic              wide_i,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int CNT_W = (RFSH_LEN > 1) ? $clog2(RFSH_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RFSH_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  rcnt;
        logic [ADDR_W-1:0] addr;
    } cyc_t;

    cyc_t st_d, st_q;

    assign last_o = active_i && (st_q.rcnt == LAST_CNT);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.rcnt = '0;
        end else if (active_i && !last_o) begin
            st_d.rcnt = st_q.rcnt + CNT_W'(1);
        end
        // The row moves on once the cycle is complete; the modulo wrap is natural.
        if (last_o) begin
            st_d.addr = st_q.addr + (wide_i ? ADDR_W'(2) : ADDR_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter
    import rfsh_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pending_i,
    input  logic   hold_req_i,
    input  logic   dma_req_i,
    input  logic   cyc_done_i,
    input  logic   rfsh_last_i,
    output owner_e owner_o,
    output logic   take_o,
    output logic   hold_ack_o
);
    typedef struct packed {
        owner_e owner;
    } arb_t;

    arb_t   st_d, st_q;
    logic   release_pt;
    owner_e pick;

    always_comb begin
        unique case (st_q.owner)
            OWN_CPU, OWN_DMA: release_pt = cyc_done_i;
            OWN_RFSH:         release_pt = rfsh_last_i;
            default:          release_pt = !hold_req_i;
        endcase
    end

    always_comb begin
        if (pending_i) begin
            pick = OWN_RFSH;
        end else if (hold_req_i) begin
            pick = OWN_HOLD;
        end else if (dma_req_i) begin
            pick = OWN_DMA;
        end else begin
            pick = OWN_CPU;
        end
    end

    always_comb begin
        st_d = st_q;
        if (release_pt) begin
            st_d.owner = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_CPU;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_o    = st_q.owner;
    assign take_o     = release_pt && pending_i;
    assign hold_ack_o = (st_q.owner == OWN_HOLD) && !pending_i;

endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter
    import rfsh_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DIV_W    = 8,
    parameter int PEND_W   = 3,
    parameter int RFSH_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              wide_bus_i,
    input  logic              cyc_done_i,
    input  logic              dma_req_i,
    input  logic              hold_req_i,
    output logic              hold_ack_o,
    output logic [1:0]        owner_o,
    output logic              rfsh_active_o,
    output logic [ADDR_W-1:0] rfsh_addr_o
);
    logic              rfsh_pending;
    logic              rfsh_take;
    logic              rfsh_last;
    logic [ADDR_W-1:0] row_addr;
    owner_e            owner;

    rfsh_interval #(
        .DIV_W (DIV_W),
        .PEND_W(PEND_W)
    ) u_intv (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_i),
        .take_i   (rfsh_take),
        .pending_o(rfsh_pending)
    );

    rfsh_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_i  (rfsh_pending),
        .hold_req_i (hold_req_i),
        .dma_req_i  (dma_req_i),
        .cyc_done_i (cyc_done_i),
        .rfsh_last_i(rfsh_last),
        .owner_o    (owner),
        .take_o     (rfsh_take),
        .hold_ack_o (hold_ack_o)
    );

    rfsh_cycle #(
        .ADDR_W  (ADDR_W),
        .RFSH_LEN(RFSH_LEN)
    ) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rfsh_take),
        .active_i(owner == OWN_RFSH),
        .wide_i  (wide_bus_i),
        .last_o  (rfsh_last),
        .addr_o  (row_addr)
    );

    assign owner_o       = owner;
    assign rfsh_active_o = (owner == OWN_RFSH);
    assign rfsh_addr_o   = rfsh_active_o ? row_addr : '0;

endmodule

// File: rtl/rfsh_bus_arbiter_chk.sv
module rfsh_bus_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_done_i,
    input logic       hold_req_i,
    input logic       hold_ack_o,
    input logic [1:0] owner_o,
    input logic       rfsh_active_o,
    input logic       rfsh_pending
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_o |-> (owner_o == 2'b11 && !rfsh_active_o));

    assert_end_of_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && owner_o != $past(owner_o)
         && ($past(owner_o) == 2'b00 || $past(owner_o) == 2'b01))
        |-> $past(cyc_done_i));

    assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(owner_o) == 2'b11 && owner_o != 2'b11)
        |-> !$past(hold_req_i));

    assert_rfsh_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rfsh_pending) && $past(owner_o) != 2'b10
         && owner_o != $past(owner_o))
        |-> owner_o == 2'b10);

endmodule

bind rfsh_bus_arbiter rfsh_bus_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_done_i   (cyc_done_i),
    .hold_req_i   (hold_req_i),
    .hold_ack_o   (hold_ack_o),
    .owner_o      (owner_o),
    .rfsh_active_o(rfsh_active_o),
    .rfsh_pending (rfsh_pending)
);

// File: tb/rfsh_bus_arbiter_tb.sv
`timescale 1ns/1ps
module rfsh_bus_arbiter_tb;
    localparam int AW  = 8;
    localparam int LEN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    div_i = '0;
    logic          wide_bus_i = 1'b0;
    logic          cyc_done_i = 1'b0;
    logic          dma_req_i = 1'b0;
    logic          hold_req_i = 1'b0;
    logic          hold_ack_o;
    logic [1:0]    owner_o;
    logic          rfsh_active_o;
    logic [AW-1:0] rfsh_addr_o;

    int n_checks = 0;
    int n_err = 0;

    // monitor state
    logic [AW-1:0] exp_addr = '0;
    logic [AW-1:0] cur_addr = '0;
    logic [AW-1:0] last_start_addr = '0;
    int run = 0;
    int n_starts = 0;
    int n_active = 0;
    int cyc = 0;
    int last_start_cyc = 0;
    int last_gap = 0;
    bit have_start = 0;

    always #2.5 clk = ~clk;

    rfsh_bus_arbiter #(
        .ADDR_W  (AW),
        .DIV_W   (8),
        .PEND_W  (3),
        .RFSH_LEN(LEN)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_i        (div_i),
        .wide_bus_i   (wide_bus_i),
        .cyc_done_i   (cyc_done_i),
        .dma_req_i    (dma_req_i),
        .hold_req_i   (hold_req_i),
        .hold_ack_o   (hold_ack_o),
        .owner_o      (owner_o),
        .rfsh_active_o(rfsh_active_o),
        .rfsh_addr_o  (rfsh_addr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        div_i = '0;
        cyc_done_i = 1'b0;
        dma_req_i = 1'b0;
        hold_req_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic wait_starts(input int k, input int limit);
        int w = 0;
        while (n_starts < k && w < limit) begin
            tick(1);
            w++;
        end
    endtask

    // Refresh monitor: start detection, address model (R3, R4, R5)
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_addr = '0;
            run = 0;
            n_starts = 0;
            n_active = 0;
            cyc = 0;
            have_start = 0;
            last_gap = 0;
        end else begin
            cyc++;
            if (rfsh_active_o) begin
                n_active++;
                if (run == 0 || run == LEN) begin
                    chk(rfsh_addr_o == exp_addr, "R4 R5 start address",
                        int'(rfsh_addr_o), int'(exp_addr));
                    cur_addr = exp_addr;
                    last_start_addr = rfsh_addr_o;
                    exp_addr = exp_addr + (wide_bus_i ? AW'(2) : AW'(1));
                    if (have_start) last_gap = cyc - last_start_cyc;
                    last_start_cyc = cyc;
                    have_start = 1;
                    n_starts++;
                    run = 1;
                end else begin
                    chk(rfsh_addr_o == cur_addr, "R3 address held",
                        int'(rfsh_addr_o), int'(cur_addr));
                    run++;
                end
            end else begin
                run = 0;
                chk(rfsh_addr_o == '0, "R3 idle address zero", int'(rfsh_addr_o), 0);
            end
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        tick(1);
        chk(owner_o == 2'b00, "R1 owner", owner_o, 0);
        chk(hold_ack_o == 1'b0, "R1 hold_ack", hold_ack_o, 0);
        chk(rfsh_active_o == 1'b0, "R1 active", rfsh_active_o, 0);

        // R2 disabled refresh
        cyc_done_i = 1'b1;
        tick(60);
        chk(n_starts == 0, "R2 div zero no refresh", n_starts, 0);

        // R2 R4 spacing sweep, both bus widths
        for (int n = 4; n <= 12; n++) begin
            do_reset();
            wide_bus_i = n[0];
            cyc_done_i = 1'b1;
            div_i = 8'(n);
            for (int k = 2; k <= 6; k++) begin
                wait_starts(k, 100);
                chk(n_starts >= k && last_gap == n, "R2 refresh spacing", last_gap, n);
            end
        end

        // R5 wrap, narrow bus
        do_reset();
        wide_bus_i = 1'b0;
        cyc_done_i = 1'b1;
        div_i = 8'd3;
        wait_starts(257, 2000);
        chk(last_start_addr == '0, "R5 narrow wrap", int'(last_start_addr), 0);
        wait_starts(260, 100);
        chk(n_starts == 260, "R5 narrow run count", n_starts, 260);

        // R5 wrap, wide bus
        do_reset();
        wide_bus_i = 1'b1;
        cyc_done_i = 1'b1;
        div_i = 8'd4;
        wait_starts(129, 1000);
        chk(last_start_addr == '0, "R5 wide wrap", int'(last_start_addr), 0);
        wide_bus_i = 1'b0;
        div_i = 8'd0;
        tick(10);

        // R10 queue saturates at 7; R7 processor keeps the bus meanwhile
        do_reset();
        cyc_done_i = 1'b0;
        div_i = 8'd1;
        tick(20);
        chk(owner_o == 2'b00, "R7 cpu holds without cycle end", owner_o, 0);
        chk(n_starts == 0, "R7 no refresh before release", n_starts, 0);
        div_i = 8'd0;
        cyc_done_i = 1'b1;
        tick(40);
        chk(n_starts == 7, "R10 queued refreshes served", n_starts, 7);
        chk(last_gap == LEN, "R10 back to back", last_gap, LEN);
        chk(n_active == 7 * LEN, "R3 refresh length", n_active, 7 * LEN);
        chk(owner_o == 2'b00, "R10 bus returns to cpu", owner_o, 0);

        // R6 R7 R8 priority among hold, DMA and processor
        do_reset();
        dma_req_i = 1'b1;
        hold_req_i = 1'b1;
        tick(5);
        chk(owner_o == 2'b00, "R7 no switch mid cycle", owner_o, 0);
        cyc_done_i = 1'b1;
        tick(1);
        cyc_done_i = 1'b0;
        chk(owner_o == 2'b11, "R6 hold beats dma", owner_o, 3);
        chk(hold_ack_o == 1'b1, "R8 hold ack", hold_ack_o, 1);
        tick(4);
        chk(owner_o == 2'b11, "R8 hold kept", owner_o, 3);
        hold_req_i = 1'b0;
        tick(1);
        chk(owner_o == 2'b01, "R6 dma beats cpu", owner_o, 1);
        chk(hold_ack_o == 1'b0, "R8 ack drops", hold_ack_o, 0);
        dma_req_i = 1'b0;
        tick(4);
        chk(owner_o == 2'b01, "R7 dma keeps bus", owner_o, 1);
        cyc_done_i = 1'b1;
        tick(1);
        cyc_done_i = 1'b0;
        chk(owner_o == 2'b00, "R6 cpu default", owner_o, 0);

        // R6 refresh beats hold and dma
        do_reset();
        dma_req_i = 1'b1;
        hold_req_i = 1'b1;
        div_i = 8'd5;
        tick(8);
        div_i = 8'd0;
        cyc_done_i = 1'b1;
        tick(1);
        cyc_done_i = 1'b0;
        chk(owner_o == 2'b10, "R6 refresh first", owner_o, 2);
        tick(LEN);
        chk(owner_o == 2'b11, "R6 hold after refresh", owner_o, 3);
        chk(hold_ack_o == 1'b1, "R8 ack after refresh", hold_ack_o, 1);

        // R9 refresh during hold
        div_i = 8'd4;
        begin
            int w = 0;
            while (hold_ack_o && w < 20) begin
                tick(1);
                w++;
            end
        end
        chk(hold_ack_o == 1'b0, "R9 ack withdrawn", hold_ack_o, 0);
        chk(owner_o == 2'b11, "R9 bus not seized", owner_o, 3);
        tick(5);
        chk(owner_o == 2'b11, "R9 waits for hold drop", owner_o, 3);
        chk(hold_ack_o == 1'b0, "R9 ack stays low", hold_ack_o, 0);
        div_i = 8'd0;
        hold_req_i = 1'b0;
        tick(1);
        chk(owner_o == 2'b10, "R9 refresh reclaims", owner_o, 2);
        tick(20);
        chk(owner_o == 2'b01, "R6 dma after refreshes", owner_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #750000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule